// File: doc/BRIEF.md
# Serial Daisy-Chain Configuration Slave

This block sits at the receiving end of a bit-serial configuration link in a chain of devices. An external configuration clock, CCLK, and a serial data line are brought in as plain inputs. Both are oversampled by the system clock, and DIN is taken on each rising CCLK edge. The stream opens with a four-bit preamble and then a 24-bit length field. That field tells this device how many of the following bits belong to it. Those bits are packed into words and handed to a local configuration store through a one-cycle valid strobe.

Once its share has been consumed, the device raises a sticky configured flag. Every later bit is passed down the chain on DOUT, moved from the rising edge at which it was sampled to the next falling edge of CCLK. The block has no upstream handshake, so several identical slaves can hang off one data line and load together.

Top module: `cfg_chain_slave`

## Requirements
- R1: DIN is taken only at a rising CCLK edge. A change of DIN while CCLK is high has no effect on the received data.
- R2: After reset the block hunts for the preamble 0,0,1,0 (in arrival order). Bits before it are neither counted nor stored, and the bit after it is the first bit of the length field.
- R3: The 24 bits following the preamble form the length count, most significant bit first. The length count is the number of bits this device keeps.
- R4: Kept bits are packed into words of WORD_W bits, with the first bit received in the most significant position. Each word is presented on wr_data with wr_valid high for exactly one system clock. When the count is not a multiple of WORD_W, the last word holds the leftover bits right-aligned, with zeros above them.
- R5: configured is low until the last kept bit has been sampled (or until the end of the length field when the count is zero). It then stays high until reset.
- R6: dout is held high from reset until the first forwarded bit is driven.
- R7: Every bit sampled after the kept share appears on dout at the falling CCLK edge that follows its sampling edge, and dout changes only in response to a falling edge.
- R8: While reset is applied, and in the cycle after it is released, dout is high, configured is low and wr_valid is low.
- R9: No word is written after configured has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than CCLK |
| rst | input | 1 | Synchronous active-high reset |
| cclk_in | input | 1 | External configuration clock, asynchronous |
| din_in | input | 1 | Serial configuration data in |
| dout | output | 1 | Forwarded serial data to the next device |
| wr_valid | output | 1 | One-cycle strobe for a captured word |
| wr_data | output | WORD_W | Captured configuration word |
| configured | output | 1 | Own share fully received (sticky) |

## Verification
Each CCLK edge goes through two synchronizer flops and an edge register. As a result, wr_valid, configured and dout all react three system clocks after cclk_in changes. The bench holds each CCLK phase for eight system clocks. It reads dout at the end of the low phase, when the falling-edge update has landed, and reads configured at the end of the high phase, when the rising-edge update is complete. Words are collected at every clock by a monitor and compared after the stream ends, against values computed from the bit pattern and the length. A sweep of lengths from 0 to 24 plus 37 exercises empty shares, full words and partial words. Flipping DIN in mid-high phase shows that only the rising-edge sample matters.

// File: rtl/cfgchain_pkg.sv
`timescale 1ns/1ps
package cfgchain_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEN,
        ST_LOAD,
        ST_PASS
    } chain_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic data;
    } cclk_evt_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cfgchain_cclk_sync.sv
`timescale 1ns/1ps
module cfgchain_cclk_sync
    import cfgchain_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cclk_in,
    input  logic      din_in,
    output cclk_evt_t evt
);

    logic [1:0] ck_sync;
    logic [1:0] d_sync;
    logic       ck_prev;

    // reset to the idle-high level so no spurious rising edge follows reset
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sync <= 2'b11;
            d_sync  <= 2'b11;
            ck_prev <= 1'b1;
        end else begin
            ck_sync <= {ck_sync[0], cclk_in};
            d_sync  <= {d_sync[0], din_in};
            ck_prev <= ck_sync[1];
        end
    end

    always_comb begin
        evt.rise = ck_sync[1] & ~ck_prev;
        evt.fall = ~ck_sync[1] & ck_prev;
        evt.data = d_sync[1];
    end

endmodule

// File: rtl/cfgchain_stream_ctrl.sv
`timescale 1ns/1ps
module cfgchain_stream_ctrl
    import cfgchain_pkg::*;
#(
    parameter int           LEN_W    = 24,
    parameter int           PRE_W    = 4,
    parameter logic [PRE_W-1:0] PREAMBLE = 4'b0010
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_rise,
    input  logic bit_data,
    output logic ld_valid,
    output logic ld_data,
    output logic ld_last,
    output logic fwd_valid,
    output logic fwd_data,
    output logic in_pass
);

    localparam int CNT_W = cnt_bits(LEN_W);
    localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN_W - 1);

    chain_state_e     state;
    logic [PRE_W-1:0] pre_sh;
    logic [LEN_W-1:0] len_sh;
    logic [CNT_W-1:0] len_cnt;
    logic [LEN_W-1:0] remain;
    logic [PRE_W-1:0] pre_next;
    logic [LEN_W-1:0] len_next;

    assign pre_next = {pre_sh[PRE_W-2:0], bit_data};
    assign len_next = {len_sh[LEN_W-2:0], bit_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            pre_sh  <= '1;
            len_sh  <= '0;
            len_cnt <= '0;
            remain  <= '0;
        end else if (bit_rise) begin
            unique case (state)
                ST_HUNT: begin
                    pre_sh <= pre_next;
                    if (pre_next == PREAMBLE) begin
                        state   <= ST_LEN;
                        len_cnt <= '0;
                        pre_sh  <= '1;
                    end
                end
                ST_LEN: begin
                    len_sh  <= len_next;
                    len_cnt <= len_cnt + 1'b1;
                    if (len_cnt == LEN_LAST) begin
                        remain <= len_next;
                        state  <= (len_next == '0) ? ST_PASS : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    remain <= remain - 1'b1;
                    if (remain == LEN_W'(1)) begin
                        state <= ST_PASS;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ld_valid  = bit_rise && (state == ST_LOAD);
        ld_data   = bit_data;
        ld_last   = (remain == LEN_W'(1));
        fwd_valid = bit_rise && (state == ST_PASS);
        fwd_data  = bit_data;
        in_pass   = (state == ST_PASS);
    end

endmodule

// File: rtl/cfgchain_word_pack.sv
`timescale 1ns/1ps
module cfgchain_word_pack
    import cfgchain_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    localparam int WC_W = cnt_bits(WORD_W);
    localparam logic [WC_W-1:0] FILL_LAST = WC_W'(WORD_W - 1);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_next;
    logic [WC_W-1:0]   fill;

    assign acc_next = {acc[WORD_W-2:0], in_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            fill      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (fill == FILL_LAST || in_last) begin
                    out_valid <= 1'b1;
                    out_data  <= acc_next;
                    acc       <= '0;
                    fill      <= '0;
                end else begin
                    acc  <= acc_next;
                    fill <= fill + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfgchain_fwd_retime.sv
`timescale 1ns/1ps
module cfgchain_fwd_retime (
    input  logic clk,
    input  logic rst,
    input  logic fwd_valid,
    input  logic fwd_data,
    input  logic cclk_fall,
    output logic dout
);

    logic hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b1;
            dout <= 1'b1;
        end else begin
            if (fwd_valid) begin
                hold <= fwd_data;
            end
            if (cclk_fall) begin
                dout <= hold;
            end
        end
    end

endmodule

// File: rtl/cfg_chain_slave.sv
`timescale 1ns/1ps
module cfg_chain_slave
    import cfgchain_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cclk_in,
    input  logic              din_in,
    output logic              dout,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_data,
    output logic              configured
);

    cclk_evt_t evt;
    logic      cclk_fall;
    logic      ld_valid, ld_data, ld_last;
    logic      fwd_valid, fwd_data;

    assign cclk_fall = evt.fall;

    cfgchain_cclk_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .cclk_in (cclk_in),
        .din_in  (din_in),
        .evt     (evt)
    );

    cfgchain_stream_ctrl #(
        .LEN_W    (LEN_W),
        .PRE_W    (4),
        .PREAMBLE (4'b0010)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bit_rise  (evt.rise),
        .bit_data  (evt.data),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .ld_last   (ld_last),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .in_pass   (configured)
    );

    cfgchain_word_pack #(
        .WORD_W (WORD_W)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ld_valid),
        .in_data   (ld_data),
        .in_last   (ld_last),
        .out_valid (wr_valid),
        .out_data  (wr_data)
    );

    cfgchain_fwd_retime u_fwd (
        .clk       (clk),
        .rst       (rst),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .cclk_fall (cclk_fall),
        .dout      (dout)
    );

endmodule

// File: rtl/cfgchain_chk.sv
`timescale 1ns/1ps
module cfgchain_chk (
    input logic clk,
    input logic rst,
    input logic dout,
    input logic wr_valid,
    input logic configured,
    input logic cclk_fall
);

    p_wr_single_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    p_cfg_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        configured |=> configured);

    p_dout_high_load_r6: assert property (@(posedge clk) disable iff (rst)
        !configured |-> dout);

    p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> $past(cclk_fall));

    p_no_word_after_cfg_r9: assert property (@(posedge clk) disable iff (rst)
        configured |=> !wr_valid);

endmodule

bind cfg_chain_slave cfgchain_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dout       (dout),
    .wr_valid   (wr_valid),
    .configured (configured),
    .cclk_fall  (cclk_fall)
);

// File: tb/sim_cfg_chain_slave.sv
`timescale 1ns/1ps
module sim_cfg_chain_slave;

    localparam int WORD_W = 8;
    localparam int LEN_W  = 24;
    localparam int HALF   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cclk_in = 1'b0;
    logic              din_in = 1'b1;
    logic              dout;
    logic              wr_valid;
    logic [WORD_W-1:0] wr_data;
    logic              configured;

    int n_cmp = 0;
    int n_bad = 0;
    int nwords = 0;
    logic last_fwd = 1'b1;
    logic [WORD_W-1:0] got [64];

    always #2.5 clk = ~clk;

    cfg_chain_slave #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .cclk_in(cclk_in), .din_in(din_in),
        .dout(dout), .wr_valid(wr_valid), .wr_data(wr_data),
        .configured(configured)
    );

    always @(negedge clk) begin
        if (rst) nwords = 0;
        else if (wr_valid === 1'b1) begin
            if (nwords < 64) got[nwords] = wr_data;
            nwords = nwords + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic dbit(input int seed, input int i);
        return logic'(((i * 11 + seed * 7 + i / 3) >> 1) & 1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cclk_in = 1'b0; din_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(dout === 1'b1 && configured === 1'b0 && wr_valid === 1'b0,
            "R8 outputs in reset", {dout, configured, wr_valid}, 3'b100);
        rst = 1'b0; last_fwd = 1'b1;
        @(negedge clk);
        chk(dout === 1'b1 && configured === 1'b0 && wr_valid === 1'b0,
            "R8 outputs after reset", {dout, configured, wr_valid}, 3'b100);
    endtask

    // one CCLK period; DIN is flipped mid-high phase to prove R1
    task automatic send_bit(input logic b, input logic fwd, input logic cfg_exp);
        @(negedge clk);
        cclk_in = 1'b0; din_in = b;
        repeat (HALF) @(negedge clk);
        chk(dout === last_fwd, "R6 R7 dout after fall", dout, last_fwd);
        cclk_in = 1'b1;
        repeat (4) @(negedge clk);
        din_in = ~b;
        repeat (HALF - 4) @(negedge clk);
        if (fwd) last_fwd = b;
        chk(configured === cfg_exp, "R5 configured", configured, cfg_exp);
    endtask

    task automatic run_stream(input int len, input int seed, input int nfwd, input bit junk);
        int nexp;
        do_reset();
        if (junk) begin
            // 1,0,1,0,0,1,1 never forms 0,0,1,0 (R2)
            send_bit(1, 0, 0); send_bit(0, 0, 0); send_bit(1, 0, 0);
            send_bit(0, 0, 0); send_bit(0, 0, 0); send_bit(1, 0, 0);
            send_bit(1, 0, 0);
        end else begin
            repeat (3) send_bit(1, 0, 0);
        end
        send_bit(0, 0, 0); send_bit(0, 0, 0); send_bit(1, 0, 0); send_bit(0, 0, 0);
        chk(nwords == 0, "R2 no word before header", nwords, 0);
        for (int i = LEN_W - 1; i >= 0; i--) send_bit(len[i], 0, (i == 0 && len == 0));
        for (int i = 0; i < len; i++) send_bit(dbit(seed, i), 0, (i == len - 1));
        for (int i = 0; i < nfwd; i++) send_bit(logic'(((i * 3 + seed) >> 1) & 1), 1, 1);
        send_bit(1, 0, 1);
        nexp = (len + WORD_W - 1) / WORD_W;
        chk(nwords == nexp, "R3 R9 word count", nwords, nexp);
        for (int k = 0; k < nexp && k < nwords && k < 64; k++) begin
            int n;
            int e;
            n = (len - k * WORD_W >= WORD_W) ? WORD_W : len - k * WORD_W;
            e = 0;
            for (int j = 0; j < n; j++) e = (e << 1) | int'(dbit(seed, k * WORD_W + j));
            chk(int'(got[k]) == e, "R1 R4 word value", int'(got[k]), e);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int l = 0; l <= 24; l++) run_stream(l, l, 6, 1'b0);
        run_stream(12, 3, 8, 1'b1);
        run_stream(37, 5, 4, 1'b0);
        summary();
        $finish;
    end

endmodule